// File: doc/BRIEF.md
# Approximate Tile Convolution Unit

This unit sits beside the execute stage of a 32-bit processor and computes a valid 3x3 convolution over a 4x4 tile of signed 32-bit words. The four results form a 2x2 block. It saves multiplications by estimating the size of each weight-times-input product from the sum of the operands' leading-one positions. Within each window, any term whose estimate falls further than a programmable distance below the window's largest estimate is dropped and contributes zero. A term whose weight or input is zero is never multiplied.

The nine weights are written ahead of time through a small write port. The unit records each weight's leading-one position as the weight is written. A command supplies a word count, a byte start address and a pruning distance. The unit reads the tile one word at a time and runs three internal passes: leading-one extraction, pruned multiplication and window summation. It then raises `done` and holds the four sums and a count of the multiplications it performed. The host releases the unit with `ack`.

Top module: `conv_approx_engine`

## Requirements
- R1: After synchronous reset, `done` and `mem_rd` are low and `result` and `mul_count` are zero.
- R2: A command issues exactly min(`cmd_size`,16) reads. Read k uses address `cmd_addr`+4k, in increasing k. A new read is issued only after the previous read's `mem_rvalid`.
- R3: Tile positions at or beyond `cmd_size` are treated as zero words. When `cmd_size` is zero, no read is made.
- R4: A weight write with `kw_idx` 0 to 8 stores weight (row = idx/3, column = idx%3). A write with any other index changes nothing.
- R5: The magnitude position of a value is the leading-one index of its absolute value, and the value 0x80000000 gives 31. In each window, the pair score is the input position plus the weight position. A pair is multiplied only if both operands are nonzero and the window's highest score among such pairs minus its own score is at most `prune_thr`.
- R6: Each output is the 32-bit wrapping sum of the low 32 bits of its kept products. Skipped pairs add exactly zero. With `prune_thr` 63, the output equals the exact convolution.
- R7: Output (r,c) covers input rows r..r+2 and columns c..c+2. It appears at `result[32*(2r+c) +: 32]`, so the word order is (0,0), (0,1), (1,0), (1,1).
- R8: While `done` is high, `mul_count` equals the number of pairs multiplied across the four windows.
- R9: `done` stays high with `result` stable until `ack` is sampled high. On the next cycle `done` is low and `result` and `mul_count` are zero.
- R10: A `start` pulse while a command is in progress is ignored. The running command keeps its address, count and threshold.
- R11: The sequence visits wait, fetch, leading-one pass, pruning pass, summation pass and done, in that order. `done` rises exactly four clock edges after the edge that samples the last `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kw_we | input | 1 | Weight write strobe |
| kw_idx | input | 4 | Weight index, row-major |
| kw_data | input | 32 | Signed weight value |
| start | input | 1 | Command strobe, taken only when idle |
| cmd_size | input | 32 | Number of tile words to fetch |
| cmd_addr | input | 32 | Byte address of the first tile word |
| prune_thr | input | 6 | Allowed score distance below the window maximum |
| mem_rd | output | 1 | Read request, one cycle per word |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Results valid, waiting for acknowledge |
| ack | input | 1 | Acknowledge releasing the unit |
| result | output | 128 | Four 32-bit sums, (0,0) in the low word |
| mul_count | output | 6 | Multiplications performed by the last command |

## Verification
A wrong sequencer state appears at the ports within a few cycles. A stuck fetch phase leaves `done` low and stops `mem_rd`. A skipped or repeated pass moves the rising edge of `done` off the fixed four-edge distance after the last returned word.

A corrupted score, maximum or keep decision shows up in the same `done` window. The affected output word departs from an independently computed pruned sum, and `mul_count` departs from the expected number of kept pairs. Words that are dropped or written to the wrong buffer slot are caught through the short-count and exact-threshold commands.

// File: rtl/conv_approx_pkg.sv
package conv_approx_pkg;

    localparam int DATA_W  = 32;
    localparam int MAG_W   = $clog2(DATA_W);
    localparam int TILE_N  = 4;
    localparam int KER_N   = 3;
    localparam int OUT_N   = TILE_N - KER_N + 1;
    localparam int IN_CNT  = TILE_N * TILE_N;
    localparam int K_CNT   = KER_N * KER_N;
    localparam int O_CNT   = OUT_N * OUT_N;
    localparam int IDX_W   = $clog2(IN_CNT + 1);
    localparam int SEL_W   = $clog2(IN_CNT);
    localparam int KIDX_W  = $clog2(K_CNT);
    localparam int SCORE_W = MAG_W + 1;
    localparam int CNT_W   = $clog2(O_CNT * K_CNT + 1);

    // magnitude estimate: nonzero flag plus leading-one index of |v|
    typedef struct packed {
        logic             nz;
        logic [MAG_W-1:0] pos;
    } mag_t;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_MSB, S_PRUNE, S_SUM, S_DONE
    } seq_t;

    function automatic mag_t mag_of(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] a;
        mag_t m;
        a = v[DATA_W-1] ? (~v + 1'b1) : v;
        m.nz  = |a;
        m.pos = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (a[i]) m.pos = MAG_W'(i);
        end
        return m;
    endfunction

    // tile index feeding kernel tap k of output window o
    function automatic int win_src(input int o, input int k);
        return ((o / OUT_N) + (k / KER_N)) * TILE_N + (o % OUT_N) + (k % KER_N);
    endfunction

endpackage

// File: rtl/conv_kernel_store.sv
module conv_kernel_store
    import conv_approx_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              kw_we,
    input  logic [KIDX_W-1:0]                 kw_idx,
    input  logic [DATA_W-1:0]                 kw_data,
    output logic [K_CNT-1:0][DATA_W-1:0]      w_q,
    output mag_t [K_CNT-1:0]                  wm_q
);

    for (genvar g = 0; g < K_CNT; g++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst) begin
                w_q[g]  <= '0;
                wm_q[g] <= '0;
            end else if (kw_we && (kw_idx == KIDX_W'(g))) begin
                w_q[g]  <= kw_data;
                wm_q[g] <= mag_of(kw_data);
            end
        end
    end

endmodule

// File: rtl/conv_prune_sel.sv
module conv_prune_sel
    import conv_approx_pkg::*;
#(
    parameter int THR_W = 6
) (
    input  mag_t [IN_CNT-1:0]              xm,
    input  mag_t [K_CNT-1:0]               wm,
    input  logic [THR_W-1:0]               thr,
    output logic [O_CNT-1:0][K_CNT-1:0]    keep
);

    localparam int CMP_W = ((SCORE_W > THR_W) ? SCORE_W : THR_W) + 1;

    for (genvar o = 0; o < O_CNT; o++) begin : g_win
        logic [K_CNT-1:0][SCORE_W-1:0] score;
        logic [K_CNT-1:0]              live;
        logic [SCORE_W-1:0]            peak;

        always_comb begin
            peak = '0;
            for (int k = 0; k < K_CNT; k++) begin
                live[k]  = xm[win_src(o, k)].nz & wm[k].nz;
                score[k] = SCORE_W'(xm[win_src(o, k)].pos) + SCORE_W'(wm[k].pos);
                if (live[k] && (score[k] > peak)) peak = score[k];
            end
            for (int k = 0; k < K_CNT; k++) begin
                keep[o][k] = live[k] && (CMP_W'(peak - score[k]) <= CMP_W'(thr));
            end
        end
    end

endmodule

// File: rtl/conv_approx_engine.sv
module conv_approx_engine
    import conv_approx_pkg::*;
#(
    parameter int THR_W = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      kw_we,
    input  logic [KIDX_W-1:0]         kw_idx,
    input  logic [DATA_W-1:0]         kw_data,
    input  logic                      start,
    input  logic [DATA_W-1:0]         cmd_size,
    input  logic [DATA_W-1:0]         cmd_addr,
    input  logic [THR_W-1:0]          prune_thr,
    output logic                      mem_rd,
    output logic [DATA_W-1:0]         mem_addr,
    input  logic                      mem_rvalid,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic                      done,
    input  logic                      ack,
    output logic [O_CNT*DATA_W-1:0]   result,
    output logic [CNT_W-1:0]          mul_count
);

    localparam int MAX_MULS = O_CNT * K_CNT;

    seq_t                                    st_q;
    logic [DATA_W-1:0]                       base_q;
    logic [IDX_W-1:0]                        lim_q, idx_q, lim_c;
    logic                                    wait_q;
    logic [THR_W-1:0]                        thr_q;
    logic [IN_CNT-1:0][DATA_W-1:0]           x_q;
    mag_t [IN_CNT-1:0]                       xm_q;
    logic [K_CNT-1:0][DATA_W-1:0]            w_q;
    mag_t [K_CNT-1:0]                        wm_q;
    logic [O_CNT-1:0][K_CNT-1:0]             keep_c, keep_q;
    logic [O_CNT-1:0][K_CNT-1:0][DATA_W-1:0] prod_q;
    logic [O_CNT-1:0][DATA_W-1:0]            sum_c, res_q;
    logic [CNT_W-1:0]                        cnt_q;

    conv_kernel_store u_kstore (
        .clk     (clk),
        .rst     (rst),
        .kw_we   (kw_we),
        .kw_idx  (kw_idx),
        .kw_data (kw_data),
        .w_q     (w_q),
        .wm_q    (wm_q)
    );

    conv_prune_sel #(.THR_W(THR_W)) u_prune (
        .xm   (xm_q),
        .wm   (wm_q),
        .thr  (thr_q),
        .keep (keep_c)
    );

    assign lim_c = (cmd_size >= DATA_W'(IN_CNT)) ? IDX_W'(IN_CNT) : cmd_size[IDX_W-1:0];

    always_comb begin
        sum_c = '0;
        for (int o = 0; o < O_CNT; o++) begin
            for (int k = 0; k < K_CNT; k++) begin
                sum_c[o] = sum_c[o] + prod_q[o][k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            base_q <= '0;
            lim_q  <= '0;
            idx_q  <= '0;
            wait_q <= 1'b0;
            thr_q  <= '0;
            x_q    <= '0;
            xm_q   <= '0;
            keep_q <= '0;
            prod_q <= '0;
            res_q  <= '0;
            cnt_q  <= '0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (start) begin
                        base_q <= cmd_addr;
                        lim_q  <= lim_c;
                        thr_q  <= prune_thr;
                        idx_q  <= '0;
                        wait_q <= 1'b0;
                        x_q    <= '0;
                        st_q   <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (wait_q) begin
                        if (mem_rvalid) begin
                            x_q[idx_q[SEL_W-1:0]] <= mem_rdata;
                            idx_q  <= idx_q + 1'b1;
                            wait_q <= 1'b0;
                        end
                    end else if (idx_q < lim_q) begin
                        wait_q <= 1'b1;
                    end else begin
                        st_q <= S_MSB;
                    end
                end
                S_MSB: begin
                    for (int i = 0; i < IN_CNT; i++) xm_q[i] <= mag_of(x_q[i]);
                    st_q <= S_PRUNE;
                end
                S_PRUNE: begin
                    keep_q <= keep_c;
                    for (int o = 0; o < O_CNT; o++) begin
                        for (int k = 0; k < K_CNT; k++) begin
                            prod_q[o][k] <= keep_c[o][k] ? DATA_W'(x_q[win_src(o, k)] * w_q[k]) : '0;
                        end
                    end
                    st_q <= S_SUM;
                end
                S_SUM: begin
                    res_q <= sum_c;
                    cnt_q <= CNT_W'($countones(keep_q));
                    st_q  <= S_DONE;
                end
                S_DONE: begin
                    if (ack) begin
                        res_q  <= '0;
                        cnt_q  <= '0;
                        keep_q <= '0;
                        prod_q <= '0;
                        xm_q   <= '0;
                        st_q   <= S_IDLE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign mem_rd    = (st_q == S_FETCH) && !wait_q && (idx_q < lim_q);
    assign mem_addr  = base_q + (DATA_W'(idx_q) << 2);
    assign done      = (st_q == S_DONE);
    assign result    = res_q;
    assign mul_count = cnt_q;

    // R2: one outstanding read at a time
    assert_single_read_R2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    // R5: a kept pair never involves a zero input
    assert_zero_skip_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_SUM) |-> ((keep_q[0][0] == 1'b0) || xm_q[0].nz));

    // R8: multiply count bounded by the number of pairs
    assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (mul_count <= CNT_W'(MAX_MULS)));

    // R9: results held until acknowledged
    assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !ack) |=> (done && $stable(result)));

    assert_done_release_R9: assert property (@(posedge clk) disable iff (rst)
        (done && ack) |=> (!done && (result == '0) && (mul_count == '0)));

    // R10: command parameters frozen while busy
    assert_ignore_start_R10: assert property (@(posedge clk) disable iff (rst)
        ((st_q != S_IDLE) && start) |=> ($stable(base_q) && $stable(lim_q) && $stable(thr_q)));

    // R11: fixed pass order
    assert_seq_msb_R11: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_MSB) |=> (st_q == S_PRUNE));
    assert_seq_prune_R11: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_PRUNE) |=> (st_q == S_SUM));
    assert_seq_sum_R11: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_SUM) |=> (st_q == S_DONE));

endmodule

// File: tb/conv_approx_engine_bench.sv
module conv_approx_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 1234;

    logic         clk = 1'b0;
    logic         rst;
    logic         kw_we;
    logic [3:0]   kw_idx;
    logic [31:0]  kw_data;
    logic         start;
    logic [31:0]  cmd_size, cmd_addr;
    logic [5:0]   prune_thr;
    logic         mem_rd;
    logic [31:0]  mem_addr;
    logic         mem_rvalid;
    logic [31:0]  mem_rdata;
    logic         done, ack;
    logic [127:0] result;
    logic [5:0]   mul_count;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [64];
    logic [31:0] ktab [9];
    logic [31:0] addr_log [1024];
    int          rd_total = 0;
    int          since = 0;
    logic        pend = 1'b0;
    logic [31:0] paddr;
    int          dly = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_approx_engine u_conv_approx_engine (
        .clk(clk), .rst(rst), .kw_we(kw_we), .kw_idx(kw_idx), .kw_data(kw_data),
        .start(start), .cmd_size(cmd_size), .cmd_addr(cmd_addr), .prune_thr(prune_thr),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .ack(ack), .result(result), .mul_count(mul_count)
    );

    // memory model with 1..3 cycle response latency
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_rvalid) since <= 0; else since <= since + 1;
        if (mem_rd) begin
            addr_log[rd_total % 1024] = mem_addr;
            rd_total = rd_total + 1;
            pend  <= 1'b1;
            paddr <= mem_addr;
            dly   <= $urandom_range(0, 2);
        end else if (pend) begin
            if (dly == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[paddr[7:2]];
                pend       <= 1'b0;
            end else begin
                dly <= dly - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int mag_ref(input logic [31:0] v);
        logic [31:0] a;
        int p;
        a = v[31] ? (32'd0 - v) : v;
        p = -1;
        while (a != 0) begin
            p++;
            a = a >> 1;
        end
        return p;
    endfunction

    task automatic load_w(input int idx, input logic [31:0] v);
        @(negedge clk);
        kw_we = 1'b1; kw_idx = idx[3:0]; kw_data = v;
        @(negedge clk);
        kw_we = 1'b0;
        if (idx < 9) ktab[idx] = v;
    endtask

    task automatic run_cmd(input int base, input int size, input int thr, input bit poke, input string tag);
        logic [31:0] tile [16];
        logic [31:0] exp_res [4];
        logic [127:0] held;
        int exp_cnt, nrd, rd_start, t;
        nrd = (size > 16) ? 16 : size;
        for (int i = 0; i < 16; i++) tile[i] = (i < nrd) ? mem[(base >> 2) + i] : 32'd0;
        exp_cnt = 0;
        for (int o = 0; o < 4; o++) begin
            int sc [9];
            bit lv [9];
            int pk;
            logic [31:0] acc;
            pk = 0; acc = 0;
            for (int k = 0; k < 9; k++) begin
                int ti, mx, mw;
                ti = ((o / 2) + (k / 3)) * 4 + (o % 2) + (k % 3);
                mx = mag_ref(tile[ti]);
                mw = mag_ref(ktab[k]);
                lv[k] = (mx >= 0) && (mw >= 0);
                sc[k] = mx + mw;
                if (lv[k] && sc[k] > pk) pk = sc[k];
            end
            for (int k = 0; k < 9; k++) begin
                int ti;
                ti = ((o / 2) + (k / 3)) * 4 + (o % 2) + (k % 3);
                if (lv[k] && (pk - sc[k] <= thr)) begin
                    acc = acc + tile[ti] * ktab[k];
                    exp_cnt++;
                end
            end
            exp_res[o] = acc;
        end
        rd_start = rd_total;
        @(negedge clk);
        cmd_addr = base; cmd_size = size; prune_thr = thr[5:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            start = 1'b1; cmd_addr = base ^ 32'h40; cmd_size = 3; prune_thr = 0;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(done, {"R11 done reached ", tag}, 32'(done), 32'd1);
        for (int o = 0; o < 4; o++)
            chk(result[32*o +: 32] == exp_res[o], $sformatf("R6 R7 R5 word %0d %s", o, tag),
                result[32*o +: 32], exp_res[o]);
        chk(mul_count == 6'(exp_cnt), {"R8 count ", tag}, 32'(mul_count), 32'(exp_cnt));
        chk((rd_total - rd_start) == nrd, {"R2 R3 read count ", tag}, 32'(rd_total - rd_start), 32'(nrd));
        for (int i = 0; i < nrd; i++)
            chk(addr_log[(rd_start + i) % 1024] == 32'(base + 4 * i), {"R2 address ", tag},
                addr_log[(rd_start + i) % 1024], 32'(base + 4 * i));
        if (nrd > 0 && !poke)
            chk(since == 4, {"R11 latency ", tag}, 32'(since), 32'd4);
        held = result;
        @(negedge clk);
        chk(done && (result == held), {"R9 hold ", tag}, 32'(done), 32'd1);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(!done && result == '0 && mul_count == '0, {"R9 release ", tag}, 32'(done), 32'd0);
    endtask

    function automatic logic [31:0] rnd_val();
        logic [31:0] v;
        if ($urandom_range(0, 4) == 0) return 32'd0;
        v = $urandom >> $urandom_range(1, 31);
        if ($urandom_range(0, 1) == 1) v = 32'd0 - v;
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(SEED));
        rst = 1'b1; kw_we = 0; kw_idx = 0; kw_data = 0; start = 0;
        cmd_size = 0; cmd_addr = 0; prune_thr = 0; ack = 0;
        for (int i = 0; i < 64; i++) mem[i] = rnd_val();
        for (int k = 0; k < 9; k++) ktab[k] = 32'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !mem_rd && result == '0 && mul_count == '0, "R1 reset state", 32'(done), 32'd0);

        for (int k = 0; k < 9; k++) load_w(k, rnd_val() | 32'd1);
        // exact convolution, full tile
        run_cmd(0, 16, 63, 0, "exact");
        // tightest pruning
        run_cmd(64, 16, 0, 0, "thr0");
        // short tile, rest zero
        run_cmd(128, 5, 63, 0, "short");
        run_cmd(128, 0, 63, 0, "empty");
        run_cmd(192, 100, 2, 0, "oversize");
        // all-zero tile
        for (int i = 32; i < 48; i++) mem[i] = 32'd0;
        run_cmd(128, 16, 63, 0, "zeros");
        // extreme magnitudes, wrapping sum
        for (int i = 32; i < 48; i++) mem[i] = (i % 2) ? 32'h8000_0000 : 32'h7fff_ffff;
        for (int k = 0; k < 9; k++) load_w(k, 32'h7fff_fff1 + k);
        run_cmd(128, 16, 63, 0, "wrap");
        run_cmd(128, 16, 1, 0, "wrap_thr1");
        // out-of-range weight indices ignored
        for (int j = 9; j < 16; j++) load_w(j, 32'hdead_beef);
        run_cmd(128, 16, 63, 0, "R4 bad index");
        // start during a running command
        run_cmd(0, 16, 4, 1, "R10 poke");
        // random mix
        for (int n = 0; n < 24; n++) begin
            for (int i = 0; i < 64; i++) mem[i] = rnd_val();
            if (n % 4 == 0) for (int k = 0; k < 9; k++) load_w(k, rnd_val());
            run_cmd(64 * $urandom_range(0, 3), $urandom_range(0, 20), $urandom_range(0, 10), 0, "random");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule